// File: doc/BRIEF.md
# Power Management Wake Event Controller

This block gathers wake events for a network controller and turns them into a power-management-event output toward the host. A single sticky wake status bit records that a wake source fired. Software clears it by writing a one. The status survives every power-state change. As a result, a status left over from an earlier wake raises the event output the moment the device re-enters the low-power state, unless software clears it first.

Software programs four control bits through one write port: an interrupt mask, a power-on wake enable, a magic packet enable and a pattern wake mode. The packet detectors sit outside this block. Each one reports a hit as a one-cycle pulse. While software sets up wake, the mask forces the normal interrupt lines low. The event output is active only while the device reports the low-power state, the power-on enable is set and the status is set.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset, the configuration readback `cfg_rd_o` is 4'b0000 and `wake_sts_o` is 0. `pme_o` is 0, and `irq_o` equals `irq_i`.
- R2: A cycle with `cfg_we_i` high loads `cfg_wdata_i` into the configuration. The new value appears on `cfg_rd_o` after the next rising edge. The field layout is bit 0 interrupt mask, bit 1 power-on enable, bit 2 magic packet enable and bit 3 pattern wake mode. When `cfg_we_i` is low, the configuration holds its value.
- R3: A `magic_evt_i` pulse sets the wake status at the next edge only if the magic packet enable is 1. Otherwise the pulse leaves the status unchanged.
- R4: A `pattern_evt_i` pulse sets the wake status at the next edge only if both pattern wake mode and power-on enable are 1. Otherwise the pulse leaves the status unchanged.
- R5: A status write (`sts_we_i` high) with `sts_wdata_i` = 1 clears the wake status at the next edge. A status write with `sts_wdata_i` = 0 has no effect.
- R6: If an accepted wake event and a clearing status write occur in the same cycle, the status ends up set.
- R7: `pme_o` is 1 exactly when `pstate_i` is 1 (low-power state, D3), the power-on enable is 1 and the wake status is 1. It follows `pstate_i` with no delay. It falls after the edge at which the status clears.
- R8: The wake status keeps its value across changes of `pstate_i` in both directions. A stale status therefore drives `pme_o` high as soon as `pstate_i` rises.
- R9: While the interrupt mask is 1, every bit of `irq_o` is 0. While the mask is 0, `irq_o` equals `irq_i` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstate_i | input | 1 | Device power state: 0 = D0, 1 = D3 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data (layout in R2) |
| cfg_rd_o | output | 4 | Current configuration |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data, 1 clears |
| magic_evt_i | input | 1 | Magic packet detector pulse |
| pattern_evt_i | input | 1 | Pattern match detector pulse |
| irq_i | input | IRQ_W | Interrupt requests from the controller core |
| irq_o | output | IRQ_W | Interrupt lines after masking |
| wake_sts_o | output | 1 | Sticky wake status |
| pme_o | output | 1 | Power management event output |

## Verification
The bench builds the block with IRQ_W = 3 rather than the default of 4. With a width of 3, masking is checked on an odd number of lines, with every bit set, so a mask that covers only some of the lines or only a fixed width is caught. The pattern and magic paths are driven with each enable combination in turn. Same-cycle set and clear collisions are also covered. The D0 to D3 round trip is run with a stale status left in place, to show the immediate event and that the status persists.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

    // Packed so that bit 0 is the mask and bit 3 the pattern mode.
    typedef struct packed {
        logic pat_mode;
        logic magic_en;
        logic pwr_en;
        logic irq_mask;
    } wake_cfg_t;

    localparam int unsigned CFG_W = $bits(wake_cfg_t);

    typedef enum logic {
        PS_D0 = 1'b0,
        PS_D3 = 1'b1
    } pstate_e;

endpackage

// File: rtl/pm_wake_cfg.sv
module pm_wake_cfg
    import pm_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  wake_cfg_t wdata_i,
    output wake_cfg_t cfg_o
);

    typedef struct packed {
        wake_cfg_t cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.cfg = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cfg_o == $past(wdata_i)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cfg_o));

endmodule

// File: rtl/pm_wake_status.sv
module pm_wake_status
    import pm_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wake_cfg_t cfg_i,
    input  logic      magic_evt_i,
    input  logic      pattern_evt_i,
    input  logic      clr_we_i,
    input  logic      clr_data_i,
    output logic      sts_o
);

    typedef struct packed {
        logic sts;
    } sts_state_t;

    sts_state_t st_d, st_q;
    logic magic_ok, pattern_ok, set_hit, clr_hit;

    always_comb begin
        magic_ok   = magic_evt_i & cfg_i.magic_en;
        pattern_ok = pattern_evt_i & cfg_i.pat_mode & cfg_i.pwr_en;
        set_hit    = magic_ok | pattern_ok;
        clr_hit    = clr_we_i & clr_data_i;
        st_d       = st_q;
        if (clr_hit) begin
            st_d.sts = 1'b0;
        end
        if (set_hit) begin
            st_d.sts = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sts;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (magic_evt_i && cfg_i.magic_en) |=> sts_o);

    // R5
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_data_i && !magic_evt_i && !pattern_evt_i) |=> !sts_o);

    // R4
    pattern_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_o && !magic_evt_i && pattern_evt_i && !cfg_i.pwr_en) |=> !sts_o);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o && !clr_we_i) |=> sts_o);

endmodule

// File: rtl/pm_wake_out.sv
module pm_wake_out
    import pm_wake_pkg::*;
#(
    parameter int unsigned IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pstate_i,
    input  wake_cfg_t        cfg_i,
    input  logic             sts_i,
    input  logic [IRQ_W-1:0] irq_i,
    output logic [IRQ_W-1:0] irq_o,
    output logic             pme_o
);

    for (genvar g = 0; g < IRQ_W; g++) begin : g_irq
        assign irq_o[g] = irq_i[g] & ~cfg_i.irq_mask;
    end

    assign pme_o = (pstate_e'(pstate_i) == PS_D3) & cfg_i.pwr_en & sts_i;

    // R7
    pme_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_o |-> (pstate_i && sts_i));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.irq_mask |-> (irq_o == '0));

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int unsigned IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pstate_i,
    input  logic             cfg_we_i,
    input  logic [3:0]       cfg_wdata_i,
    output logic [3:0]       cfg_rd_o,
    input  logic             sts_we_i,
    input  logic             sts_wdata_i,
    input  logic             magic_evt_i,
    input  logic             pattern_evt_i,
    input  logic [IRQ_W-1:0] irq_i,
    output logic [IRQ_W-1:0] irq_o,
    output logic             wake_sts_o,
    output logic             pme_o
);

    wake_cfg_t cfg;
    logic      sts;

    pm_wake_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (wake_cfg_t'(cfg_wdata_i)),
        .cfg_o   (cfg)
    );

    pm_wake_status u_sts (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_i         (cfg),
        .magic_evt_i   (magic_evt_i),
        .pattern_evt_i (pattern_evt_i),
        .clr_we_i      (sts_we_i),
        .clr_data_i    (sts_wdata_i),
        .sts_o         (sts)
    );

    pm_wake_out #(.IRQ_W(IRQ_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pstate_i (pstate_i),
        .cfg_i    (cfg),
        .sts_i    (sts),
        .irq_i    (irq_i),
        .irq_o    (irq_o),
        .pme_o    (pme_o)
    );

    assign cfg_rd_o   = cfg;
    assign wake_sts_o = sts;

    // R1
    rst_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_rd_o == 4'b0000 && !wake_sts_o && !pme_o));

endmodule

// File: tb/pm_wake_ctrl_bench.sv
module pm_wake_ctrl_bench;

    localparam int unsigned IRQ_W = 3;
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pstate_i = 1'b0;
    logic             cfg_we_i = 1'b0;
    logic [3:0]       cfg_wdata_i = '0;
    logic [3:0]       cfg_rd_o;
    logic             sts_we_i = 1'b0;
    logic             sts_wdata_i = 1'b0;
    logic             magic_evt_i = 1'b0;
    logic             pattern_evt_i = 1'b0;
    logic [IRQ_W-1:0] irq_i = '0;
    logic [IRQ_W-1:0] irq_o;
    logic             wake_sts_o;
    logic             pme_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    localparam logic [3:0] B_MASK = 4'b0001;
    localparam logic [3:0] B_PWR  = 4'b0010;
    localparam logic [3:0] B_MAG  = 4'b0100;
    localparam logic [3:0] B_PAT  = 4'b1000;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_wake_ctrl #(.IRQ_W(IRQ_W)) u_pm_wake_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pstate_i      (pstate_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .cfg_rd_o      (cfg_rd_o),
        .sts_we_i      (sts_we_i),
        .sts_wdata_i   (sts_wdata_i),
        .magic_evt_i   (magic_evt_i),
        .pattern_evt_i (pattern_evt_i),
        .irq_i         (irq_i),
        .irq_o         (irq_o),
        .wake_sts_o    (wake_sts_o),
        .pme_o         (pme_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_at_neg();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [3:0] v);
        drive_at_neg();
        cfg_we_i = 1'b1; cfg_wdata_i = v;
        step();
        cfg_we_i = 1'b0;
    endtask

    task automatic wr_sts(input logic v);
        drive_at_neg();
        sts_we_i = 1'b1; sts_wdata_i = v;
        step();
        sts_we_i = 1'b0; sts_wdata_i = 1'b0;
    endtask

    task automatic pulse(input logic mag, input logic pat);
        drive_at_neg();
        magic_evt_i = mag; pattern_evt_i = pat;
        step();
        magic_evt_i = 1'b0; pattern_evt_i = 1'b0;
    endtask

    task automatic t_reset();
        irq_i = 3'b101;
        #1;
        check("R1 cfg", {4'h0, cfg_rd_o}, 8'h00);
        check("R1 sts", {7'h0, wake_sts_o}, 8'h00);
        check("R1 pme", {7'h0, pme_o}, 8'h00);
        check("R1 irq", {5'h0, irq_o}, 8'h05);
    endtask

    task automatic t_cfg();
        wr_cfg(4'b1010);
        check("R2 load", {4'h0, cfg_rd_o}, 8'h0A);
        step(); step();
        check("R2 hold", {4'h0, cfg_rd_o}, 8'h0A);
        wr_cfg(4'b0000);
        check("R2 reload", {4'h0, cfg_rd_o}, 8'h00);
    endtask

    task automatic t_magic();
        wr_cfg(B_PWR);
        pulse(1'b1, 1'b0);
        check("R3 magic ignored when disabled", {7'h0, wake_sts_o}, 8'h00);
        wr_cfg(B_MAG);
        pulse(1'b1, 1'b0);
        check("R3 magic accepted", {7'h0, wake_sts_o}, 8'h01);
        wr_sts(1'b1);
    endtask

    task automatic t_pattern();
        wr_cfg(B_PAT);
        pulse(1'b0, 1'b1);
        check("R4 pattern needs pwr en", {7'h0, wake_sts_o}, 8'h00);
        wr_cfg(B_PWR | B_MAG);
        pulse(1'b0, 1'b1);
        check("R4 pattern needs mode", {7'h0, wake_sts_o}, 8'h00);
        wr_cfg(B_PWR | B_PAT);
        pulse(1'b0, 1'b1);
        check("R4 pattern accepted", {7'h0, wake_sts_o}, 8'h01);
    endtask

    task automatic t_clear();
        // status is set on entry
        wr_sts(1'b0);
        check("R5 zero write no effect", {7'h0, wake_sts_o}, 8'h01);
        wr_sts(1'b1);
        check("R5 one write clears", {7'h0, wake_sts_o}, 8'h00);
    endtask

    task automatic t_collision();
        wr_cfg(B_PWR | B_MAG);
        pulse(1'b1, 1'b0);
        drive_at_neg();
        sts_we_i = 1'b1; sts_wdata_i = 1'b1; magic_evt_i = 1'b1;
        step();
        sts_we_i = 1'b0; sts_wdata_i = 1'b0; magic_evt_i = 1'b0;
        check("R6 set wins over clear", {7'h0, wake_sts_o}, 8'h01);
        wr_sts(1'b1);
    endtask

    task automatic t_pme_sticky();
        wr_cfg(B_PWR | B_MAG);
        pulse(1'b1, 1'b0);
        check("R7 no pme in D0", {7'h0, pme_o}, 8'h00);
        drive_at_neg();
        pstate_i = 1'b1; #1;
        check("R8 stale status raises pme on D3 entry", {7'h0, pme_o}, 8'h01);
        drive_at_neg();
        pstate_i = 1'b0; step();
        check("R8 status kept through D3 to D0", {7'h0, wake_sts_o}, 8'h01);
        drive_at_neg();
        pstate_i = 1'b1; #1;
        wr_cfg(B_MAG);
        check("R7 pme needs pwr en", {7'h0, pme_o}, 8'h00);
        wr_cfg(B_PWR | B_MAG);
        check("R7 pme back with pwr en", {7'h0, pme_o}, 8'h01);
        drive_at_neg();
        sts_we_i = 1'b1; sts_wdata_i = 1'b1; #1;
        check("R7 pme held until clear edge", {7'h0, pme_o}, 8'h01);
        step();
        sts_we_i = 1'b0; sts_wdata_i = 1'b0;
        check("R7 pme falls after clear", {7'h0, pme_o}, 8'h00);
        drive_at_neg();
        pstate_i = 1'b0;
    endtask

    task automatic t_mask();
        irq_i = 3'b111;
        wr_cfg(B_MASK);
        check("R9 masked all lines", {5'h0, irq_o}, 8'h00);
        wr_cfg(4'b0000);
        check("R9 unmasked", {5'h0, irq_o}, 8'h07);
        drive_at_neg();
        irq_i = 3'b010; #1;
        check("R9 pass-through", {5'h0, irq_o}, 8'h02);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (2) @(posedge clk);
        drive_at_neg();
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_magic();
        t_pattern();
        t_clear();
        t_collision();
        t_pme_sticky();
        t_mask();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule